// File: doc/BRIEF.md
# Variable-Length Base-128 Integer Encoder

The block converts a fixed-width integer into its shortest little-endian base-128 byte form. It works in one of two modes, chosen per item. In unsigned mode the value is a plain binary number. In signed mode the value is read as two's complement. The value is cut into 7-bit groups starting from bit 0. Each group becomes one byte, and the top bit of each byte says whether another byte follows. All output bytes are produced in parallel, lowest group first, together with a count of how many of them are meaningful.

Items enter and leave through valid/ready handshakes, with one register stage between them. The input accepts an item on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure from `out_ready` therefore stalls the input directly. A result held under back-pressure is not changed until it has been taken.

Top module: `leb_varint_enc`

## Requirements
- R1: Output byte k carries bits 7k..7k+6 of the value in its bits 6..0, and byte 0 holds the least significant group.
- R2: Bit 7 of every meaningful byte except the last is 1, and bit 7 of the last meaningful byte (index count-1) is 0.
- R3: In unsigned mode (`in_signed`=0) the count is the index of the highest group holding a 1 bit, plus one. For example, 624485 gives the bytes 0xE5 0x8E 0x26 with a count of 3.
- R4: In signed mode (`in_signed`=1) the count is the smallest n for which bit 6 of group n-1 and every bit above it equal the sign bit. For example, -624485 gives the bytes 0x9B 0xF1 0x59 with a count of 3.
- R5: Byte slots at index count and above are 0x00.
- R6: Zero encodes as the single byte 0x00 with a count of 1 in both modes, and the count is always between 1 and ceil(W/7).
- R7: At the 7-bit signed boundaries, in signed mode: -1 gives 0x7F, 63 gives 0x3F, -64 gives 0x40 (one byte each), 64 gives 0xC0 0x00, and -65 gives 0xBF 0x7F.
- R8: The bits of the top group that lie above the input width are filled with 0 in unsigned mode and with the sign bit in signed mode. With W=64, all ones in unsigned mode gives nine 0xFF bytes and then 0x01. The signed minimum gives nine 0x80 bytes and then 0x7F. The signed maximum gives nine 0xFF bytes and then 0x00.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. An item accepted on an edge appears on the outputs with `out_valid` high right after that edge, and the outputs hold still while `out_valid` is high and `out_ready` is low. Results leave in the order the items were accepted.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input item is offered |
| in_ready | output | 1 | The input item is taken on this edge |
| in_value | input | DATA_W | Integer to encode |
| in_signed | input | 1 | 1: two's complement mode, 0: unsigned mode |
| out_valid | output | 1 | The output register holds a result |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_bytes | output | 8*ceil(DATA_W/7) | Encoded bytes, byte k at bits 8k+7..8k |
| out_count | output | clog2(ceil(DATA_W/7)+1) | Number of meaningful bytes |

## Verification
Each result is due on the outputs one clock after the edge that accepts its input. It stays there, unchanged, until the first edge on which `out_ready` is high. The bench drives inputs one time unit after a rising edge and samples on falling edges. The driver pushes the expected encoding at the falling edge before the accepting edge. The monitor pops and compares an item at the falling edge before the edge that takes it, so a result that arrives late, early or changes during a stall shows up as a mismatch. During stalled cycles the bench also checks that `in_ready` is low.

// File: rtl/leb_enc_pkg.sv
`timescale 1ns/1ps
package leb_enc_pkg;
  // number of 7-bit groups needed for a w-bit integer
  function automatic int groups_for(input int w);
    return (w + 6) / 7;
  endfunction
  // bits needed to hold a byte count from 0 to n
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/leb_group_split.sv
`timescale 1ns/1ps
module leb_group_split #(
  parameter int DATA_W = 64,
  parameter int NGRP   = 10
) (
  input  logic [DATA_W-1:0] value,
  input  logic              signed_mode,
  output logic [NGRP*7-1:0] groups,
  output logic              fill
);
  localparam int PAD = NGRP * 7 - DATA_W;

  // top-group padding bit: sign in signed mode, zero otherwise
  assign fill = signed_mode & value[DATA_W-1];

  generate
    if (PAD > 0) begin : g_pad
      assign groups = {{PAD{fill}}, value};
    end else begin : g_nopad
      assign groups = value;
    end
  endgenerate
endmodule

// File: rtl/leb_len_calc.sv
`timescale 1ns/1ps
module leb_len_calc #(
  parameter int NGRP  = 10,
  parameter int CNT_W = 4
) (
  input  logic [NGRP*7-1:0] groups,
  input  logic              fill,
  input  logic              signed_mode,
  output logic [CNT_W-1:0]  count
);
  // above_fill[g]: every group from g upward consists only of fill bits
  logic [NGRP:0] above_fill;

  always_comb begin
    above_fill[NGRP] = 1'b1;
    for (int g = NGRP - 1; g >= 0; g--) begin
      above_fill[g] = above_fill[g+1] && (groups[7*g +: 7] == {7{fill}});
    end
  end

  // smallest n that drops only redundant groups; in signed mode the
  // kept top bit must also repeat the sign
  always_comb begin
    count = CNT_W'(NGRP);
    for (int n = NGRP - 1; n >= 1; n--) begin
      if (above_fill[n] && (!signed_mode || (groups[7*n-1] == fill))) begin
        count = CNT_W'(n);
      end
    end
  end
endmodule

// File: rtl/leb_byte_pack.sv
`timescale 1ns/1ps
module leb_byte_pack #(
  parameter int NGRP  = 10,
  parameter int CNT_W = 4
) (
  input  logic [NGRP*7-1:0] groups,
  input  logic [CNT_W-1:0]  count,
  output logic [NGRP*8-1:0] bytes
);
  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_byte
      localparam logic [CNT_W-1:0] IDX  = CNT_W'(k);
      localparam logic [CNT_W-1:0] NEXT = CNT_W'(k + 1);
      assign bytes[8*k +: 8] = (IDX < count) ? {(NEXT < count), groups[7*k +: 7]}
                                             : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/leb_varint_enc.sv
`timescale 1ns/1ps
module leb_varint_enc
  import leb_enc_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NGRP  = groups_for(DATA_W),
  localparam int CNT_W = count_bits(NGRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_value,
  input  logic              in_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NGRP*8-1:0] out_bytes,
  output logic [CNT_W-1:0]  out_count
);
  logic [NGRP*7-1:0] grp;
  logic              fill;
  logic [CNT_W-1:0]  cnt_c;
  logic [NGRP*8-1:0] bytes_c;

  leb_group_split #(.DATA_W(DATA_W), .NGRP(NGRP)) u_split (
    .value(in_value), .signed_mode(in_signed), .groups(grp), .fill(fill)
  );

  leb_len_calc #(.NGRP(NGRP), .CNT_W(CNT_W)) u_len (
    .groups(grp), .fill(fill), .signed_mode(in_signed), .count(cnt_c)
  );

  leb_byte_pack #(.NGRP(NGRP), .CNT_W(CNT_W)) u_pack (
    .groups(grp), .count(cnt_c), .bytes(bytes_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bytes <= '0;
      out_count <= '0;
    end else begin
      if (in_valid && in_ready) begin
        out_valid <= 1'b1;
        out_bytes <= bytes_c;
        out_count <= cnt_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // framing checks on the registered result
  logic cont_ok, pad_ok;
  always_comb begin
    cont_ok = 1'b1;
    pad_ok  = 1'b1;
    for (int k = 0; k < NGRP; k++) begin
      if (k < int'(out_count) - 1) begin
        if (!out_bytes[8*k+7]) cont_ok = 1'b0;
      end else if (k == int'(out_count) - 1) begin
        if (out_bytes[8*k+7]) cont_ok = 1'b0;
      end else begin
        if (out_bytes[8*k +: 8] != 8'h00) pad_ok = 1'b0;
      end
    end
  end

  a_r2_cont_bits: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cont_ok);
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pad_ok);
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= CNT_W'(1)) && (out_count <= CNT_W'(NGRP)));
  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bytes) && $stable(out_count)));
endmodule

// File: tb/leb_varint_enc_bench.sv
`timescale 1ns/1ps
module leb_varint_enc_bench;
  localparam int W  = 64;
  localparam int NG = (W + 6) / 7;
  localparam int CW = $clog2(NG + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, in_valid, in_ready, in_signed, out_valid, out_ready;
  logic [W-1:0]    in_value;
  logic [NG*8-1:0] out_bytes;
  logic [CW-1:0]   out_count;

  leb_varint_enc #(.DATA_W(W)) u_leb_varint_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_signed(in_signed), .out_valid(out_valid),
    .out_ready(out_ready), .out_bytes(out_bytes), .out_count(out_count)
  );

  int tests = 0, fails = 0;
  logic bp_en = 1'b0;
  logic [NG*8-1:0] exp_b[$];
  int              exp_n[$];
  string           exp_t[$];

  function automatic void ref_enc(input logic [W-1:0] val, input logic sgn,
                                  output logic [NG*8-1:0] b, output int n);
    logic [W-1:0] v;
    logic [6:0]   g;
    logic         done;
    b = '0; n = 0; v = val; done = 1'b0;
    for (int i = 0; i < NG; i++) begin
      if (!done) begin
        g = v[6:0];
        if (sgn) v = $signed(v) >>> 7;
        else     v = v >> 7;
        if (sgn) done = ((v == '0) && !g[6]) || ((v == '1) && g[6]);
        else     done = (v == '0);
        if (i == NG - 1) done = 1'b1;
        b[8*i +: 8] = {!done, g};
        n = i + 1;
      end
    end
  endfunction

  task automatic send(input logic [W-1:0] val, input logic sgn, input string tag);
    logic [NG*8-1:0] b;
    int n;
    ref_enc(val, sgn, b, n);
    in_value  = val;
    in_signed = sgn;
    in_valid  = 1'b1;
    do @(negedge clk); while (!in_ready);
    exp_b.push_back(b);
    exp_n.push_back(n);
    exp_t.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_ready) begin
        tests++;
        if (exp_b.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected result %h count %0d, expected none", out_bytes, out_count);
        end else begin
          logic [NG*8-1:0] eb;
          int en;
          string et;
          eb = exp_b.pop_front();
          en = exp_n.pop_front();
          et = exp_t.pop_front();
          if (out_bytes !== eb || int'(out_count) != en) begin
            fails++;
            $display("FAIL %s: bytes %h count %0d, expected bytes %h count %0d",
                     et, out_bytes, out_count, eb, en);
          end
        end
      end else begin
        tests++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R9: in_ready %b during stall, expected 0", in_ready);
        end
      end
    end
  end

  // consumer back-pressure
  always @(posedge clk) begin
    #1 out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_value = '0; in_signed = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10: out_valid %b in_ready %b, expected 0 1", out_valid, in_ready);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    send(64'd624485, 1'b0, "R3");
    send(-64'sd624485, 1'b1, "R4");
    send(64'd0, 1'b0, "R6");
    send(64'd0, 1'b1, "R6");
    send(-64'sd1, 1'b1, "R7");
    send(64'd63, 1'b1, "R7");
    send(-64'sd64, 1'b1, "R7");
    send(64'd64, 1'b1, "R7");
    send(-64'sd65, 1'b1, "R7");
    send(64'd64, 1'b0, "R3");
    send(64'd5, 1'b0, "R5");
    send(64'h0123_4567_89AB_CDEF, 1'b0, "R1");
    send(64'h0000_0000_0FFF_FFFF, 1'b0, "R2");
    send('1, 1'b0, "R8");
    send({1'b1, 63'd0}, 1'b1, "R8");
    send({1'b0, {63{1'b1}}}, 1'b1, "R8");
    send({1'b1, 63'd0}, 1'b0, "R8");

    bp_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] v;
      v = {$urandom, $urandom};
      v = v >> $urandom_range(0, 63);
      if (i % 3 == 0) v = ~v;
      send(v, i[0], (i % 2 == 0) ? "R1" : "R9");
    end

    for (int i = 0; i < 2000 && exp_b.size() != 0; i++) @(posedge clk);
    @(negedge clk);
    tests++;
    if (exp_b.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d results missing, expected 0", exp_b.size());
    end
    summary();
  end
endmodule